// File: doc/BRIEF.md
# Auto-Reload Wakeup Timer

This block is a periodic wakeup timer. A down-counter advances on a tick enable that is chosen from five tick inputs. While the timer is enabled, a sticky wakeup flag is raised once every (reload + 1) selected ticks. Software clears the flag with a one-cycle clear pulse.

A 3-bit select chooses the tick source. When the select's top bit is 1, the slow one-per-second tick drives the counter. In that mode the counter is 17 bits wide, and the select's middle bit serves as the top bit of the reload.

The 16-bit reload register can only be written while the write-allowed output is high. That output is low whenever the timer is enabled, and it stays low for two selected ticks after the enable is removed.

The control is a four-state machine:
- **IDLE**: stopped. Writes are allowed when enable is low. Enable moves it to RUN and loads the counter.
- **RUN**: counting on selected ticks. Dropping enable moves it to DRAIN1.
- **DRAIN1**: a selected tick moves it to DRAIN2. Enable moves it back to RUN with a fresh load.
- **DRAIN2**: a selected tick moves it to IDLE. Enable moves it back to RUN with a fresh load.

Top module: `wakeup_timer`

## Requirements
- R1: After reset, `wake_flag` is 0, `wr_allowed` is 1, and the reload value is 0xFFFF, so the first wake comes 65536 selected ticks after enable.
- R2: The first `wake_flag` rise comes on the clock edge of the (reload + 1)-th selected tick after the edge that samples `enable` high from IDLE. It is visible in the next cycle.
- R3: While enable stays high, the flag is set again every (reload + 1) selected ticks.
- R4: Tick selection:
  - `tick_in` bit 0 is clock/16, bit 1 is clock/8, bit 2 is clock/4, bit 3 is clock/2, and bit 4 is the one-per-second tick.
  - Select codes 3'b000 to 3'b011 choose bits 0 to 3.
  - Codes 3'b1xx choose bit 4.
- R5: With `clk_sel[2]`=1, the effective reload is the 17-bit value {`clk_sel[1]`, reload}.
- R6: `wake_flag` stays set until a `flag_clr` pulse. A set and a clear on the same edge leave it set.
- R7: `wr_allowed` is low in any cycle where `enable` is high. After `enable` falls, it returns high on the edge of the second selected tick.
- R8: A reload write while `wr_allowed` is 0 is ignored.
- R9: Ticks on inputs that are not selected do not advance the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Timer enable |
| clk_sel | input | 3 | Tick source select; bit 1 doubles as reload bit 16 when bit 2 is set |
| tick_in | input | 5 | Tick enables: /16, /8, /4, /2, one-per-second |
| reload_wr | input | 1 | Reload write strobe |
| reload_wdata | input | 16 | Reload write data |
| flag_clr | input | 1 | Wakeup flag clear pulse |
| wake_flag | output | 1 | Sticky wakeup flag |
| wr_allowed | output | 1 | Reload writes accepted when high |

## Verification
A wrong count or reload in the counter shows as a `wake_flag` rise one or more ticks early or late. For the first period this appears within (reload + 1) ticks of enable, and it repeats every period after that. A state machine stuck in RUN or a drain state leaves `wr_allowed` low past the second tick after disable, which is visible within two ticks. A leaked write shows up only at the next period boundary, as a changed interval.

// File: rtl/wkt_pkg.sv
package wkt_pkg;
    typedef enum logic [1:0] {
        S_IDLE   = 2'd0,
        S_RUN    = 2'd1,
        S_DRAIN1 = 2'd2,
        S_DRAIN2 = 2'd3
    } wkt_state_e;

    localparam int SEL_W    = 3;
    localparam int N_TICKS  = 5;
    localparam int SEC_TICK = 4;
endpackage

// File: rtl/wkt_tick_sel.sv
module wkt_tick_sel
    import wkt_pkg::*;
#(
    parameter int NT = N_TICKS
) (
    input  logic [SEL_W-1:0] sel,
    input  logic [NT-1:0]    ticks,
    output logic             tick_o
);
    localparam int FAST_N = NT - 1;

    logic [FAST_N-1:0] fast_hit;

    genvar g;
    generate
        for (g = 0; g < FAST_N; g++) begin : g_fast
            assign fast_hit[g] = ticks[g] && (sel[1:0] == g[1:0]);
        end
    endgenerate

    always_comb begin
        if (sel[2]) tick_o = ticks[NT-1];
        else        tick_o = |fast_hit;
    end
endmodule

// File: rtl/wkt_ctrl.sv
module wkt_ctrl
    import wkt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable,
    input  logic       sel_tick,
    output wkt_state_e state_o,
    output logic       load_o,
    output logic       count_en_o,
    output logic       wr_allowed_o
);
    wkt_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:   if (enable) state_d = S_RUN;
            S_RUN:    if (!enable) state_d = S_DRAIN1;
            S_DRAIN1: begin
                if (enable)        state_d = S_RUN;
                else if (sel_tick) state_d = S_DRAIN2;
            end
            S_DRAIN2: begin
                if (enable)        state_d = S_RUN;
                else if (sel_tick) state_d = S_IDLE;
            end
            default:  state_d = S_IDLE;
        endcase
    end

    always_comb begin
        load_o       = 1'b0;
        count_en_o   = 1'b0;
        wr_allowed_o = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                load_o       = enable;
                wr_allowed_o = !enable;
            end
            S_RUN:    count_en_o = enable && sel_tick;
            S_DRAIN1: load_o     = enable;
            S_DRAIN2: load_o     = enable;
            default: ;
        endcase
    end

    assign state_o = state_q;
endmodule

// File: rtl/wkt_counter.sv
module wkt_counter #(
    parameter int CW = 17
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic          count_en,
    input  logic [CW-1:0] reload_eff,
    input  logic          flag_clr,
    output logic          wake_flag
);
    logic [CW-1:0] cnt_q;
    logic          wrap;

    assign wrap = count_en && (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load || wrap) begin
            cnt_q <= reload_eff;
        end else if (count_en) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        wake_flag <= 1'b0;
        else if (wrap)     wake_flag <= 1'b1;
        else if (flag_clr) wake_flag <= 1'b0;
    end
endmodule

// File: rtl/wakeup_timer.sv
module wakeup_timer
    import wkt_pkg::*;
#(
    parameter int          RELOAD_W   = 16,
    parameter logic [15:0] RELOAD_RST = 16'hFFFF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic [2:0]          clk_sel,
    input  logic [4:0]          tick_in,
    input  logic                reload_wr,
    input  logic [RELOAD_W-1:0] reload_wdata,
    input  logic                flag_clr,
    output logic                wake_flag,
    output logic                wr_allowed
);
    localparam int EXT_W = RELOAD_W + 1;

    logic [RELOAD_W-1:0] reload_q;
    logic [EXT_W-1:0]    reload_eff;
    logic                sel_tick;
    logic                load;
    logic                count_en;
    wkt_state_e          ctrl_state;

    wkt_tick_sel #(.NT(N_TICKS)) u_sel (
        .sel    (clk_sel),
        .ticks  (tick_in),
        .tick_o (sel_tick)
    );

    wkt_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .enable       (enable),
        .sel_tick     (sel_tick),
        .state_o      (ctrl_state),
        .load_o       (load),
        .count_en_o   (count_en),
        .wr_allowed_o (wr_allowed)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       reload_q <= RELOAD_W'(RELOAD_RST);
        else if (reload_wr && wr_allowed) reload_q <= reload_wdata;
    end

    assign reload_eff = {clk_sel[2] & clk_sel[1], reload_q};

    wkt_counter #(.CW(EXT_W)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (load),
        .count_en   (count_en),
        .reload_eff (reload_eff),
        .flag_clr   (flag_clr),
        .wake_flag  (wake_flag)
    );
endmodule

// File: rtl/wkt_checker.sv
module wkt_checker
    import wkt_pkg::*;
#(
    parameter int RW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          enable,
    input logic          reload_wr,
    input logic          flag_clr,
    input logic          wake_flag,
    input logic          wr_allowed,
    input logic [1:0]    state,
    input logic [RW-1:0] reload_q
);
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_flag && !flag_clr) |=> wake_flag);

    a_r7_wa_low_when_en: assert property (@(posedge clk) disable iff (!rst_n)
        enable |-> !wr_allowed);

    a_r7_wa_rise_after_drain: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_allowed) |-> ($past(state) == 2'(S_DRAIN2)));

    a_r8_reload_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_allowed || !reload_wr) |=> $stable(reload_q));

    a_r2_no_flag_from_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (state == 2'(S_IDLE) && !wake_flag) |=> !wake_flag);
endmodule

bind wakeup_timer wkt_checker #(.RW(RELOAD_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .reload_wr  (reload_wr),
    .flag_clr   (flag_clr),
    .wake_flag  (wake_flag),
    .wr_allowed (wr_allowed),
    .state      (ctrl_state),
    .reload_q   (reload_q)
);

// File: tb/wakeup_timer_tb.sv
module wakeup_timer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        enable = 1'b0;
    logic [2:0]  clk_sel = 3'b000;
    logic [4:0]  tick_in = 5'b0;
    logic        reload_wr = 1'b0;
    logic [15:0] reload_wdata = 16'h0;
    logic        flag_clr = 1'b0;
    logic        wake_flag;
    logic        wr_allowed;

    int total = 0;
    int bad = 0;
    int cycles = 0;

    // reference model state: 0 idle, 1 run, 2 drain
    int          m_st = 0;
    int          m_cnt = 0;
    int          m_drn = 0;
    logic [15:0] m_reload = 16'hFFFF;
    logic        m_flag = 1'b0;

    always #10 clk = ~clk;

    wakeup_timer u_dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clk_sel(clk_sel),
        .tick_in(tick_in), .reload_wr(reload_wr), .reload_wdata(reload_wdata),
        .flag_clr(flag_clr), .wake_flag(wake_flag), .wr_allowed(wr_allowed)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles == 200000) begin
            bad++;
            $display("FAIL watchdog: run did not finish");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    function automatic int eff_of(input logic [2:0] s, input logic [15:0] r);
        return int'(r) + ((s[2] && s[1]) ? 65536 : 0);
    endfunction

    function automatic logic pick(input logic [2:0] s, input logic [4:0] t);
        if (s[2]) return t[4];
        return t[s[1:0]];
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0b expected=%0b at cycle %0d", req, act, exp, cycles);
        end
    endtask

    // called at a negedge with inputs already driven
    task automatic cyc(input string req);
        logic st;
        logic set;
        #1;
        check(req, wake_flag, m_flag);
        check("R7", wr_allowed, (m_st == 0) && !enable);
        st  = pick(clk_sel, tick_in);
        set = 1'b0;
        if (reload_wr && (m_st == 0) && !enable) m_reload = reload_wdata;
        if (m_st == 0) begin
            if (enable) begin m_st = 1; m_cnt = 0; end
        end else if (m_st == 1) begin
            if (!enable) begin m_st = 2; m_drn = 0; end
            else if (st) begin
                m_cnt++;
                if (m_cnt == eff_of(clk_sel, m_reload) + 1) begin set = 1'b1; m_cnt = 0; end
            end
        end else begin
            if (enable) begin m_st = 1; m_cnt = 0; end
            else if (st) begin
                m_drn++;
                if (m_drn == 2) m_st = 0;
            end
        end
        m_flag = set | (m_flag & ~flag_clr);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic stop_and_load(input logic [15:0] val);
        enable = 1'b0; reload_wr = 1'b0; flag_clr = 1'b1; tick_in = 5'h1F;
        for (int i = 0; i < 6; i++) cyc("R7");
        flag_clr = 1'b0;
        reload_wr = 1'b1; reload_wdata = val;
        cyc("R7");
        reload_wr = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R1", wake_flag, 1'b0);
        check("R1", wr_allowed, 1'b1);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: default reload 0xFFFF, one-per-second tick every cycle
        clk_sel = 3'b100; tick_in = 5'b10000; enable = 1'b1;
        for (int i = 0; i < 65540; i++) cyc("R1");
        check("R1", wake_flag, 1'b1);

        // R2: first flag after reload+1 random ticks on /2 source
        stop_and_load(16'd5);
        clk_sel = 3'b011; enable = 1'b1;
        for (int i = 0; i < 60; i++) begin
            tick_in = 5'($urandom);
            flag_clr = ($urandom % 8) == 0;
            cyc("R2");
        end
        flag_clr = 1'b0;

        // R3 / R4: random episodes over all select codes
        for (int ep = 0; ep < 14; ep++) begin
            logic [2:0]  s;
            logic [15:0] r;
            s = 3'($urandom);
            if (s[2]) s[1] = 1'b0;
            r = 16'($urandom % 16);
            if (s == 3'b011 && r == 0) r = 16'd1;
            stop_and_load(r);
            clk_sel = s; enable = 1'b1;
            for (int i = 0; i < 80; i++) begin
                tick_in = 5'($urandom);
                flag_clr = ($urandom % 8) == 0;
                cyc((ep % 2 == 0) ? "R3" : "R4");
            end
            flag_clr = 1'b0;
        end

        // R9: only unselected ticks pulse
        stop_and_load(16'd2);
        clk_sel = 3'b000; enable = 1'b1;
        for (int i = 0; i < 50; i++) begin
            tick_in = 5'($urandom) & 5'b11110;
            cyc("R9");
        end
        check("R9", wake_flag, 1'b0);

        // R8: writes while enabled are ignored, period keeps old reload
        clk_sel = 3'b001;
        reload_wr = 1'b1; reload_wdata = 16'd0;
        for (int i = 0; i < 4; i++) begin tick_in = 5'b0; cyc("R8"); end
        reload_wr = 1'b0;
        for (int i = 0; i < 20; i++) begin
            tick_in = 5'b00010;
            flag_clr = (i % 5) == 4;
            cyc("R8");
        end
        flag_clr = 1'b0;

        // R6: period of one tick with clear held: set wins
        stop_and_load(16'd0);
        clk_sel = 3'b101; enable = 1'b1; tick_in = 5'b10000; flag_clr = 1'b1;
        for (int i = 0; i < 10; i++) cyc("R6");
        check("R6", wake_flag, 1'b1);
        tick_in = 5'b0;
        for (int i = 0; i < 3; i++) cyc("R6");
        flag_clr = 1'b0;
        check("R6", wake_flag, 1'b0);

        // R5: 17-bit reload {1, 0x0000} = 65536, period 65537 ticks
        stop_and_load(16'd0);
        clk_sel = 3'b110; enable = 1'b1; tick_in = 5'b10000;
        for (int i = 0; i < 65540; i++) cyc("R5");
        check("R5", wake_flag, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule